// File: doc/BRIEF.md
# Descriptor Completion Condition Unit

This block settles what a descriptor-driven DMA channel does once its current command has finished. Three mask-and-compare tests run against the four device-status bits of the channel status word. One test can hold completion back (wait). One decides whether an interrupt is raised. One decides whether the command pointer jumps to the descriptor's dependency word or steps on to the next 16-byte descriptor.

A channel sequencer pulses `start` when a command ends. With that pulse it presents the command's three 2-bit mode fields, the current pointer, the dependency word, the residual count and whether the command moved data. While the wait test holds, the unit stalls. It watches the status word and re-tests whenever the word changes. Once the wait clears it does the following, in this order:
- It requests a write-back of the status snapshot, plus the residual for data commands, and holds that request until it is acknowledged.
- It pulses the flush-clear and, if selected, the interrupt.
- It presents the next pointer and updates its branch-taken flag.

Top module: `dsc_done_ctrl`

## Requirements
- R1: A condition is true when (status[3:0] AND mask) equals (compare AND mask). The mask is select bits 19:16 and the compare value is select bits 3:0. Each of the three tests uses its own select input.
- R2: A mode field value of 0 never takes, 1 takes when the condition is true, 2 takes when it is false, and 3 always takes. The interrupt mode and the branch mode both follow this encoding.
- R3: While the wait test takes, `stalled` is high. No write-back request, interrupt, flush-clear or pointer load happens.
- R4: A stalled command is re-tested in every cycle in which the status word differs from the previous cycle. It leaves the stall only when the wait test no longer takes. A status change that keeps the wait true leaves it stalled.
- R5: On completion `wb_req` rises and stays high until `wb_ack`. It carries the status word seen when the wait cleared, held stable. `wb_res_valid` is 1 only for data commands, and `wb_residual` then carries the residual given at `start`.
- R6: In the cycle after the acknowledge, `flush_clr` pulses for one cycle. `irq_pulse` pulses in that same cycle when the interrupt test takes. `ptr_load` follows one cycle later.
- R7: When the branch test takes, `next_ptr` equals the dependency word at `ptr_load`, and `bt_flag` is 1 from the next cycle.
- R8: Otherwise `next_ptr` equals the current pointer plus 16 modulo 2^32, and `bt_flag` is 0 from the next cycle.
- R9: A `start` that arrives while the unit is busy is ignored. The command already in progress completes with its own pointer, dependency word and modes.
- R10: After reset the unit is idle, with `busy`, `wb_req`, `irq_pulse`, `ptr_load` and `bt_flag` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Command finished; capture the command fields |
| is_xfer | input | 1 | Command moved data (residual is written back) |
| wait_mode | input | 2 | Wait mode field |
| intr_mode | input | 2 | Interrupt mode field |
| br_mode | input | 2 | Branch mode field |
| wait_sel | input | 32 | Wait select register |
| intr_sel | input | 32 | Interrupt select register |
| br_sel | input | 32 | Branch select register |
| chan_status | input | 16 | Channel status word; bits 3:0 are device status |
| cur_ptr | input | 32 | Current command pointer |
| dep_word | input | 32 | Descriptor dependency word (branch target) |
| residual | input | 16 | Residual byte count of a data command |
| wb_ack | input | 1 | Write-back acknowledge |
| busy | output | 1 | A command is being completed |
| stalled | output | 1 | Completion held by the wait test |
| wb_req | output | 1 | Write-back request |
| wb_status | output | 16 | Status snapshot to store |
| wb_residual | output | 16 | Residual to store |
| wb_res_valid | output | 1 | Residual is to be stored |
| flush_clr | output | 1 | One-cycle pulse: clear the flush flag |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| ptr_load | output | 1 | One-cycle pulse: load `next_ptr` |
| next_ptr | output | 32 | Next command pointer |
| bt_flag | output | 1 | Branch-taken status flag |

## Verification
The interrupt and branch tests are swept over every mask, compare value and device-status nibble. One pass pairs "if true" with "if false" and a second pass swaps them, so a wrong mask bit, a swapped mask/compare field or an inverted mode shows up as a mismatch in the interrupt count, `next_ptr` or `bt_flag`. The wait test is swept with all four modes over every mask and compare pair, which separates commands that stall from those that complete. Directed runs cover the following:
- a status change that keeps the stall, and one that releases it;
- a `start` during a stall;
- a delayed acknowledge that must hold the request and its snapshot;
- a data command against a non-data command for the residual flag.

// File: rtl/dsc_done_pkg.sv
// Shared types for the descriptor completion condition unit.
// Assumes: mode fields are 2 bits wide, encoded as listed in cond_mode_e.
package dsc_done_pkg;
    typedef enum logic [1:0] {
        MODE_NEVER    = 2'd0,
        MODE_IF_TRUE  = 2'd1,
        MODE_IF_FALSE = 2'd2,
        MODE_ALWAYS   = 2'd3
    } cond_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_EVAL  = 3'd1,
        ST_STALL = 3'd2,
        ST_WB    = 3'd3,
        ST_INTR  = 3'd4,
        ST_BR    = 3'd5
    } done_state_e;

    localparam int TEST_WAIT = 0;
    localparam int TEST_INTR = 1;
    localparam int TEST_BR   = 2;
    localparam int NUM_TESTS = 3;
endpackage

// File: rtl/dsc_cond_test.sv
// One mask-and-compare condition test followed by mode selection.
// Assumes: the mask sits at MASK_LSB and the compare value at bit 0 of sel.
// Purely combinational.
module dsc_cond_test
    import dsc_done_pkg::*;
#(
    parameter int SEL_W    = 32,
    parameter int DEV_W    = 4,
    parameter int MASK_LSB = 16
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [DEV_W-1:0] dev,
    input  cond_mode_e       mode,
    output logic             hit
);
    logic [DEV_W-1:0] mask;
    logic [DEV_W-1:0] value;
    logic             match;
    logic             sel_unused;

    // Bits outside the two fields carry no meaning for this test.
    assign sel_unused = ^{sel[SEL_W-1:MASK_LSB+DEV_W], sel[MASK_LSB-1:DEV_W]};

    // Compare the masked device bits, then apply the mode.
    always_comb begin
        mask  = sel[MASK_LSB +: DEV_W];
        value = sel[DEV_W-1:0];
        match = ((dev & mask) == (value & mask));
        unique case (mode)
            MODE_NEVER:    hit = 1'b0;
            MODE_IF_TRUE:  hit = match;
            MODE_IF_FALSE: hit = !match;
            default:       hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/dsc_ptr_step.sv
// Next command pointer: the branch target or a sequential step.
// Assumes: descriptors are STEP bytes apart; wraps modulo 2^PTR_W.
module dsc_ptr_step #(
    parameter int PTR_W = 32,
    parameter int STEP  = 16
) (
    input  logic [PTR_W-1:0] cur_ptr,
    input  logic [PTR_W-1:0] dep_word,
    input  logic             take,
    output logic [PTR_W-1:0] next_ptr
);
    localparam logic [PTR_W-1:0] STEP_V = PTR_W'(STEP);

    // Choose the target.
    always_comb next_ptr = take ? dep_word : (cur_ptr + STEP_V);
endmodule

// File: rtl/dsc_done_fsm.sv
// Completion sequencer: evaluate, stall, write back, interrupt, branch.
// Assumes: wait_hit is combinational from the live status word. A stall is
// re-tested only in cycles where that word differs from the previous cycle.
module dsc_done_fsm
    import dsc_done_pkg::*;
#(
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wait_hit,
    input  logic [STAT_W-1:0] status_now,
    input  logic              wb_ack,
    output done_state_e       state,
    output logic              take_cmd,
    output logic              enter_wb
);
    done_state_e       state_q;
    done_state_e       state_d;
    logic [STAT_W-1:0] prev_q;
    logic              changed;

    // Detect a status change since the previous cycle.
    always_comb changed = (status_now != prev_q);

    // Next-state logic of the completion sequence.
    always_comb begin
        state_d  = state_q;
        take_cmd = 1'b0;
        enter_wb = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start) begin
                take_cmd = 1'b1;
                state_d  = ST_EVAL;
            end
            ST_EVAL: begin
                enter_wb = !wait_hit;
                state_d  = wait_hit ? ST_STALL : ST_WB;
            end
            ST_STALL: if (changed && !wait_hit) begin
                enter_wb = 1'b1;
                state_d  = ST_WB;
            end
            ST_WB:   if (wb_ack) state_d = ST_INTR;
            ST_INTR: state_d = ST_BR;
            default: state_d = ST_IDLE;
        endcase
    end

    // State and previous-status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            prev_q  <= '0;
        end else begin
            state_q <= state_d;
            prev_q  <= status_now;
        end
    end

    assign state = state_q;
endmodule

// File: rtl/dsc_done_ctrl.sv
// Top of the descriptor completion condition unit.
// Captures the finished command, runs the wait, interrupt and branch tests
// against chan_status[DEV_W-1:0], and sequences write-back, flush-clear,
// interrupt and pointer update. Assumes the select registers are stable
// while they are in use, and that wb_ack only answers wb_req.
module dsc_done_ctrl
    import dsc_done_pkg::*;
#(
    parameter int PTR_W    = 32,
    parameter int SEL_W    = 32,
    parameter int STAT_W   = 16,
    parameter int CNT_W    = 16,
    parameter int DEV_W    = 4,
    parameter int MASK_LSB = 16,
    parameter int STEP     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_xfer,
    input  logic [1:0]        wait_mode,
    input  logic [1:0]        intr_mode,
    input  logic [1:0]        br_mode,
    input  logic [SEL_W-1:0]  wait_sel,
    input  logic [SEL_W-1:0]  intr_sel,
    input  logic [SEL_W-1:0]  br_sel,
    input  logic [STAT_W-1:0] chan_status,
    input  logic [PTR_W-1:0]  cur_ptr,
    input  logic [PTR_W-1:0]  dep_word,
    input  logic [CNT_W-1:0]  residual,
    input  logic              wb_ack,
    output logic              busy,
    output logic              stalled,
    output logic              wb_req,
    output logic [STAT_W-1:0] wb_status,
    output logic [CNT_W-1:0]  wb_residual,
    output logic              wb_res_valid,
    output logic              flush_clr,
    output logic              irq_pulse,
    output logic              ptr_load,
    output logic [PTR_W-1:0]  next_ptr,
    output logic              bt_flag
);
    cond_mode_e        mode_q [NUM_TESTS];
    logic [SEL_W-1:0]  sel_arr [NUM_TESTS];
    logic [NUM_TESTS-1:0] hit;
    logic [PTR_W-1:0]  ptr_q;
    logic [PTR_W-1:0]  dep_q;
    logic [CNT_W-1:0]  res_q;
    logic              xfer_q;
    logic [STAT_W-1:0] snap_q;
    logic              bt_q;
    done_state_e       state;
    logic              take_cmd;
    logic              enter_wb;

    // Route the live select registers to their tests.
    always_comb begin
        sel_arr[TEST_WAIT] = wait_sel;
        sel_arr[TEST_INTR] = intr_sel;
        sel_arr[TEST_BR]   = br_sel;
    end

    // One condition test per mode field.
    for (genvar g = 0; g < NUM_TESTS; g++) begin : g_test
        dsc_cond_test #(
            .SEL_W    (SEL_W),
            .DEV_W    (DEV_W),
            .MASK_LSB (MASK_LSB)
        ) u_test (
            .sel  (sel_arr[g]),
            .dev  (chan_status[DEV_W-1:0]),
            .mode (mode_q[g]),
            .hit  (hit[g])
        );
    end

    dsc_done_fsm #(
        .STAT_W (STAT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .wait_hit   (hit[TEST_WAIT]),
        .status_now (chan_status),
        .wb_ack     (wb_ack),
        .state      (state),
        .take_cmd   (take_cmd),
        .enter_wb   (enter_wb)
    );

    dsc_ptr_step #(
        .PTR_W (PTR_W),
        .STEP  (STEP)
    ) u_step (
        .cur_ptr  (ptr_q),
        .dep_word (dep_q),
        .take     (hit[TEST_BR]),
        .next_ptr (next_ptr)
    );

    // Capture the finished command's fields when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q[TEST_WAIT] <= MODE_NEVER;
            mode_q[TEST_INTR] <= MODE_NEVER;
            mode_q[TEST_BR]   <= MODE_NEVER;
            ptr_q  <= '0;
            dep_q  <= '0;
            res_q  <= '0;
            xfer_q <= 1'b0;
        end else if (take_cmd) begin
            mode_q[TEST_WAIT] <= cond_mode_e'(wait_mode);
            mode_q[TEST_INTR] <= cond_mode_e'(intr_mode);
            mode_q[TEST_BR]   <= cond_mode_e'(br_mode);
            ptr_q  <= cur_ptr;
            dep_q  <= dep_word;
            res_q  <= residual;
            xfer_q <= is_xfer;
        end
    end

    // Snapshot the status word at the moment completion proceeds.
    always_ff @(posedge clk) begin
        if (!rst_n)        snap_q <= '0;
        else if (enter_wb) snap_q <= chan_status;
    end

    // Branch-taken flag, updated with each pointer load.
    always_ff @(posedge clk) begin
        if (!rst_n)                bt_q <= 1'b0;
        else if (state == ST_BR)   bt_q <= hit[TEST_BR];
    end

    // Outputs decoded from the sequencer state.
    always_comb begin
        busy         = (state != ST_IDLE);
        stalled      = (state == ST_STALL);
        wb_req       = (state == ST_WB);
        wb_status    = snap_q;
        wb_residual  = res_q;
        wb_res_valid = xfer_q;
        flush_clr    = (state == ST_INTR);
        irq_pulse    = (state == ST_INTR) && hit[TEST_INTR];
        ptr_load     = (state == ST_BR);
        bt_flag      = bt_q;
    end
endmodule

// File: rtl/dsc_done_chk.sv
// Checker for dsc_done_ctrl, bound into every instance.
// Assumes the port names of the top module.
module dsc_done_chk #(
    parameter int STAT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              stalled,
    input logic              wb_req,
    input logic              wb_ack,
    input logic [STAT_W-1:0] wb_status,
    input logic              flush_clr,
    input logic              irq_pulse,
    input logic              ptr_load,
    input logic              bt_flag,
    input logic [STAT_W-1:0] chan_status
);
    assert_reset_idle_R10: assert property (@(posedge clk)
        !rst_n |=> (!busy && !wb_req && !bt_flag));

    assert_stall_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stalled |-> (!wb_req && !irq_pulse && !flush_clr && !ptr_load));

    assert_stall_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stalled && $stable(chan_status)) |=> stalled);

    assert_wb_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> wb_req);

    assert_wb_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> $stable(wb_status));

    assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    assert_irq_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(wb_req && wb_ack));

    assert_irq_with_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> flush_clr);

    assert_load_after_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_load |-> $past(flush_clr));

    assert_bt_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bt_flag) |-> $past(ptr_load));

    assert_bt_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bt_flag) |-> ($past(ptr_load) || $past(!rst_n)));
endmodule

bind dsc_done_ctrl dsc_done_chk #(.STAT_W(STAT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .stalled     (stalled),
    .wb_req      (wb_req),
    .wb_ack      (wb_ack),
    .wb_status   (wb_status),
    .flush_clr   (flush_clr),
    .irq_pulse   (irq_pulse),
    .ptr_load    (ptr_load),
    .bt_flag     (bt_flag),
    .chan_status (chan_status)
);

// File: tb/dsc_done_ctrl_tb.sv
module dsc_done_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_xfer = 1'b0;
    logic [1:0]  wait_mode = 2'd0, intr_mode = 2'd0, br_mode = 2'd0;
    logic [31:0] wait_sel = '0, intr_sel = '0, br_sel = '0;
    logic [15:0] chan_status = '0;
    logic [31:0] cur_ptr = '0, dep_word = '0;
    logic [15:0] residual = '0;
    logic        wb_ack = 1'b0;
    logic        busy, stalled, wb_req, wb_res_valid, flush_clr, irq_pulse, ptr_load, bt_flag;
    logic [15:0] wb_status, wb_residual;
    logic [31:0] next_ptr;

    int checks = 0;
    int errors = 0;

    // Observations from the last watch.
    bit          obs_wb, obs_load, obs_stalled, obs_bt, obs_res_valid, obs_wb_changed;
    int          obs_irq, obs_ack_k, obs_irq_k, obs_flush_k, obs_load_k;
    logic [15:0] obs_wb_status, obs_residual;
    logic [31:0] obs_next;

    always #4 clk = ~clk;

    dsc_done_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_xfer(is_xfer),
        .wait_mode(wait_mode), .intr_mode(intr_mode), .br_mode(br_mode),
        .wait_sel(wait_sel), .intr_sel(intr_sel), .br_sel(br_sel),
        .chan_status(chan_status), .cur_ptr(cur_ptr), .dep_word(dep_word),
        .residual(residual), .wb_ack(wb_ack), .busy(busy), .stalled(stalled),
        .wb_req(wb_req), .wb_status(wb_status), .wb_residual(wb_residual),
        .wb_res_valid(wb_res_valid), .flush_clr(flush_clr), .irq_pulse(irq_pulse),
        .ptr_load(ptr_load), .next_ptr(next_ptr), .bt_flag(bt_flag)
    );

    function automatic bit cond_f(logic [31:0] sel, logic [3:0] dev);
        return ((dev & sel[19:16]) == (sel[3:0] & sel[19:16]));
    endfunction

    function automatic bit take_f(int mode, bit c);
        case (mode)
            0: return 1'b0;
            1: return c;
            2: return !c;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [31:0] mk_sel(int mask, int val, int noise);
        return {12'(noise), 4'(mask), 12'(noise * 3), 4'(val)};
    endfunction

    task automatic chk(string req, bit ok, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        start = 1'b0;
        wb_ack = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic start_cmd();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Sample at negedges, acknowledge after ack_delay cycles of request.
    task automatic watch(input int ack_delay);
        int waited = 0;
        obs_wb = 0; obs_load = 0; obs_stalled = 0; obs_bt = 0; obs_wb_changed = 0;
        obs_irq = 0; obs_ack_k = -1; obs_irq_k = -1; obs_flush_k = -1; obs_load_k = -1;
        for (int k = 0; k < 16; k++) begin
            obs_stalled = stalled;
            if (wb_req) begin
                if (obs_wb && wb_status != obs_wb_status) obs_wb_changed = 1;
                obs_wb = 1;
                obs_wb_status = wb_status;
                obs_res_valid = wb_res_valid;
                obs_residual = wb_residual;
                if (waited >= ack_delay) begin
                    wb_ack = 1'b1;
                    obs_ack_k = k;
                end else begin
                    waited++;
                end
            end
            if (irq_pulse) begin
                obs_irq++;
                obs_irq_k = k;
            end
            if (flush_clr) obs_flush_k = k;
            if (ptr_load) begin
                obs_load = 1;
                obs_next = next_ptr;
                obs_load_k = k;
                break;
            end
            @(negedge clk);
            wb_ack = 1'b0;
        end
        if (obs_load) begin
            @(negedge clk);
            obs_bt = bt_flag;
        end
    endtask

    // Run one command through the interrupt/branch tests and check the results.
    task automatic run_ib(int im, int bm, int idx);
        bit ic, bc, itake, btake;
        logic [31:0] exp_next;
        cur_ptr  = 32'h1000_0000 + 32'(idx) * 32'd16;
        dep_word = 32'h8000_0040 ^ (32'(idx) << 4);
        if (idx == 5) cur_ptr = 32'hFFFF_FFF0;
        intr_mode = 2'(im);
        br_mode = 2'(bm);
        wait_mode = 2'd0;
        start_cmd();
        watch(0);
        ic = cond_f(intr_sel, chan_status[3:0]);
        bc = cond_f(br_sel, chan_status[3:0]);
        itake = take_f(im, ic);
        btake = take_f(bm, bc);
        exp_next = btake ? dep_word : cur_ptr + 32'd16;
        chk("R2 interrupt decision", obs_irq == int'(itake), obs_irq, itake);
        chk(btake ? "R7 branch target" : "R8 sequential step",
            obs_load && obs_next == exp_next, obs_next, exp_next);
        chk(btake ? "R7 bt_flag set" : "R8 bt_flag clear", obs_bt == btake, obs_bt, btake);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        do_reset();
        @(negedge clk);
        // R10: idle after reset.
        chk("R10 busy", !busy, busy, 0);
        chk("R10 wb_req", !wb_req, wb_req, 0);
        chk("R10 irq/load", !irq_pulse && !ptr_load, {irq_pulse, ptr_load}, 0);
        chk("R10 bt_flag", !bt_flag, bt_flag, 0);

        // R1, R2, R7, R8: exhaustive mask/value/status sweep, two mode pairings.
        for (int pass = 0; pass < 2; pass++) begin
            for (int m = 0; m < 16; m++) begin
                for (int v = 0; v < 16; v++) begin
                    for (int d = 0; d < 16; d++) begin
                        intr_sel = mk_sel(m, v, d + pass);
                        br_sel   = mk_sel(v, m, 7 - d);
                        chan_status = {12'(m * 16 + v + pass * 5), 4'(d)};
                        run_ib(pass == 0 ? 1 : 2, pass == 0 ? 2 : 1, m * 256 + v * 16 + d);
                    end
                end
            end
        end
        // R2: never and always modes.
        for (int d = 0; d < 16; d++) begin
            intr_sel = mk_sel(d, 15 - d, 1);
            br_sel   = mk_sel(15 - d, d, 2);
            chan_status = 16'(d);
            run_ib(0, 3, d);
            run_ib(3, 0, d + 16);
        end

        // R3: wait sweep over all modes, masks and values.
        intr_mode = 2'd3;
        intr_sel = '0;
        br_sel = '0;
        for (int wm = 0; wm < 4; wm++) begin
            for (int m = 0; m < 16; m++) begin
                for (int v = 0; v < 16; v++) begin
                    bit stall_exp;
                    wait_sel = mk_sel(m, v, wm);
                    chan_status = 16'((m * 7 + v * 3 + wm) & 15);
                    stall_exp = take_f(wm, cond_f(wait_sel, chan_status[3:0]));
                    wait_mode = 2'(wm);
                    br_mode = 2'd0;
                    cur_ptr = 32'h0000_2000;
                    start_cmd();
                    watch(0);
                    if (stall_exp) begin
                        chk("R3 stalled", obs_stalled, obs_stalled, 1);
                        chk("R3 nothing while stalled", !obs_wb && obs_irq == 0 && !obs_load,
                            {obs_wb, obs_load}, 0);
                        do_reset();
                    end else begin
                        chk("R3 completes", obs_wb && obs_load && obs_irq == 1,
                            {obs_wb, obs_load}, 3);
                    end
                end
            end
        end

        // R4 and R9: stall, non-releasing change, ignored start, release.
        do_reset();
        wait_mode = 2'd1;
        wait_sel = mk_sel(1, 1, 0);
        intr_mode = 2'd0;
        br_mode = 2'd0;
        chan_status = 16'h0001;
        cur_ptr = 32'h0000_4000;
        dep_word = 32'h0000_9990;
        start_cmd();
        watch(0);
        chk("R4 initial stall", obs_stalled && !obs_wb, obs_stalled, 1);
        chan_status = 16'h0F01;
        watch(0);
        chk("R4 stays stalled on change that keeps wait", obs_stalled && !obs_wb, obs_wb, 0);
        cur_ptr = 32'h0000_7770;
        dep_word = 32'h0000_5550;
        br_mode = 2'd3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chan_status = 16'h0F00;
        watch(0);
        chk("R4 released after change", obs_wb && obs_load, {obs_wb, obs_load}, 3);
        chk("R9 start while busy ignored", obs_next == 32'h0000_4010, obs_next, 32'h0000_4010);
        chk("R5 snapshot at release", obs_wb_status == 16'h0F00, obs_wb_status, 16'h0F00);

        // R5 and R6: delayed acknowledge with a data command.
        wait_mode = 2'd0;
        intr_mode = 2'd3;
        br_mode = 2'd3;
        is_xfer = 1'b1;
        residual = 16'h1234;
        chan_status = 16'hA5C3;
        cur_ptr = 32'h0000_0100;
        dep_word = 32'h0000_0A00;
        start_cmd();
        chan_status = 16'hA5C3;
        watch(3);
        chk("R5 request held", obs_wb && !obs_wb_changed && obs_ack_k >= 3, obs_ack_k, 3);
        chk("R5 status snapshot", obs_wb_status == 16'hA5C3, obs_wb_status, 16'hA5C3);
        chk("R5 residual valid", obs_res_valid && obs_residual == 16'h1234, obs_residual, 16'h1234);
        chk("R6 irq after ack", obs_irq == 1 && obs_irq_k == obs_ack_k + 1, obs_irq_k, obs_ack_k + 1);
        chk("R6 flush with irq", obs_flush_k == obs_ack_k + 1, obs_flush_k, obs_ack_k + 1);
        chk("R6 load after irq", obs_load_k == obs_ack_k + 2, obs_load_k, obs_ack_k + 2);
        chk("R7 bt set", obs_bt && obs_next == 32'h0000_0A00, obs_next, 32'h0000_0A00);

        // R5 non-data command, R8 bt cleared by a sequential step.
        is_xfer = 1'b0;
        intr_mode = 2'd0;
        br_mode = 2'd0;
        cur_ptr = 32'h0000_0A00;
        start_cmd();
        watch(0);
        chk("R5 no residual for non-data", !obs_res_valid, obs_res_valid, 0);
        chk("R6 flush without irq", obs_irq == 0 && obs_flush_k == obs_ack_k + 1, obs_irq, 0);
        chk("R8 bt cleared", !obs_bt && obs_next == 32'h0000_0A10, obs_next, 32'h0000_0A10);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule